// File: doc/BRIEF.md
# Masked-Key Multicast Packet Router

This block is the routing stage of one node in a chip-level packet network. Each packet holds a 32-bit control word, a 32-bit routing key naming the sender, and, when a flag in the control word is set, a 32-bit payload word. The key alone decides where a packet goes. It is compared in one cycle against a table of masked entries, and the lowest-indexed entry that matches supplies a multicast destination vector. That vector has one bit for each inter-chip link of a six-direction triangular mesh and one bit for each local processing core. The packet is offered at once to every output whose bit is set.

Delivery is best effort. If a packet arriving from a mesh link matches nothing, it continues straight across the node and leaves on the opposite link. If a packet injected by a core matches nothing, or if the matching entry selects no outputs, the packet is dropped and flagged. Each output has its own valid/ready handshake. Any selected output that has not accepted the packet within a set number of cycles is abandoned. The block then raises a one-cycle error pulse that carries the packet key and the mask of outputs that failed. The input is held off until the current packet has been resolved.

Top module: `mcast_key_router`

## Requirements
- R1: A table write (cfg_we high, with index, valid flag, value, mask and destination) takes effect for packets accepted in any later cycle. Writing an entry with its valid flag low removes it from matching.
- R2: A valid entry matches a key when (key AND mask) equals (entry value AND mask). Key bits where the mask is zero are ignored.
- R3: When several valid entries match, the entry with the lowest index supplies the destination vector.
- R4: Destination bit i for i = 0..5 is mesh link i, and bit 6+c is core c. In the cycle after acceptance, out_valid equals the chosen vector. out_ctrl and out_key then carry the accepted words and stay unchanged while the packet is pending.
- R5: A packet from link d (in_from_link=1, d in 0..5) that matches no entry is sent only on link (d+3) mod 6.
- R6: A packet that matches no entry and came from a core, or from a link direction of 6 or 7, is dropped. So is a packet whose matching entry has an all-zero vector. In the cycle after acceptance no out_valid bit is set, and err_valid is high with err_unrouted=1, err_mask=0 and err_key equal to the key.
- R7: When control bit 0 is 1, out_payload carries the payload word. When it is 0, out_payload reads zero.
- R8: in_ready is low from the cycle after acceptance until every selected output has either completed its handshake or timed out. Each output's valid bit falls in the cycle after its handshake. A packet that every selected output accepts at once holds the outputs for exactly one cycle.
- R9: An output that sees valid for TIMEOUT_CYCLES cycles without ready is dropped. A handshake in the last of those cycles still counts. In the next cycle err_valid pulses with err_unrouted=0, err_mask set to the failed outputs and err_key set to the key, and in_ready is high.
- R10: After the reset is released and two clock edges have passed, in_ready is high and out_valid and err_valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cfg_we | input | 1 | Table write enable |
| cfg_idx | input | 5 | Table entry index |
| cfg_valid | input | 1 | Valid flag for the written entry |
| cfg_key | input | 32 | Entry value |
| cfg_mask | input | 32 | Entry mask |
| cfg_dest | input | 22 | Entry destination vector |
| in_valid | input | 1 | Packet offered |
| in_ready | output | 1 | Router can accept a packet |
| in_from_link | input | 1 | 1: packet came from a mesh link, 0: from a local core |
| in_link_dir | input | 3 | Arrival link direction when in_from_link is 1 |
| in_ctrl | input | 32 | Control word; bit 0 marks a payload word |
| in_key | input | 32 | Routing key (sender identity) |
| in_payload | input | 32 | Optional payload word |
| out_valid | output | 22 | Per-output valid, bits 0..5 links, 6..21 cores |
| out_ready | input | 22 | Per-output ready |
| out_ctrl | output | 32 | Control word of the pending packet |
| out_key | output | 32 | Key of the pending packet |
| out_payload | output | 32 | Payload of the pending packet, zero if absent |
| err_valid | output | 1 | One-cycle drop report |
| err_unrouted | output | 1 | Drop was caused by having no destination |
| err_key | output | 32 | Key of the dropped packet |
| err_mask | output | 22 | Outputs that timed out |

## Verification
A wrong valid bit or a wrong priority in the table shows up in the cycle after acceptance: out_valid then carries the wrong vector, or a packet that should have been flagged as unrouted turns up on an output. A pending vector or timer that is not maintained correctly changes how long in_ready stays low and the cycle in which err_valid fires. So the bench counts the cycles of each pending packet exactly against TIMEOUT_CYCLES, including a ready that arrives in the very last cycle. A sweep of keys across an overlapping table, from every arrival direction, compares each vector and drop report with an arithmetic model.

// File: rtl/mkr_pkg.sv
package mkr_pkg;
  localparam int unsigned WORD_W     = 32;
  localparam int unsigned MESH_LINKS = 6;
  localparam int unsigned DIR_W      = 3;
  localparam int unsigned PAYLOAD_FLAG_BIT = 0;

  typedef struct packed {
    logic [WORD_W-1:0] ctrl;
    logic [WORD_W-1:0] key;
    logic [WORD_W-1:0] payload;
  } mkr_pkt_t;

  // One-hot vector for the link opposite to the arrival direction.
  function automatic logic [MESH_LINKS-1:0] opposite_link(input logic [DIR_W-1:0] dir);
    logic [MESH_LINKS-1:0] v;
    v = '0;
    for (int d = 0; d < MESH_LINKS; d++) begin
      if (dir == DIR_W'(d)) v[(d + MESH_LINKS/2) % MESH_LINKS] = 1'b1;
    end
    return v;
  endfunction
endpackage

// File: rtl/mkr_key_table.sv
module mkr_key_table #(
  parameter int unsigned ENTRIES = 32,
  parameter int unsigned DEST_W  = 22,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic                      clk,
  input  logic                      rst_ni,
  input  logic                      wr_en,
  input  logic [IDX_W-1:0]          wr_idx,
  input  logic                      wr_valid,
  input  logic [mkr_pkg::WORD_W-1:0] wr_key,
  input  logic [mkr_pkg::WORD_W-1:0] wr_mask,
  input  logic [DEST_W-1:0]         wr_dest,
  input  logic [mkr_pkg::WORD_W-1:0] lk_key,
  output logic                      lk_hit,
  output logic [DEST_W-1:0]         lk_dest
);
  import mkr_pkg::*;

  logic [ENTRIES-1:0] ent_valid_q, ent_valid_d;
  logic [WORD_W-1:0]  ent_key_q  [ENTRIES];
  logic [WORD_W-1:0]  ent_mask_q [ENTRIES];
  logic [DEST_W-1:0]  ent_dest_q [ENTRIES];
  logic [ENTRIES-1:0] match;
  logic [ENTRIES-1:0] first;

  always_comb begin
    ent_valid_d = ent_valid_q;
    if (wr_en) ent_valid_d[wr_idx] = wr_valid;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) ent_valid_q <= '0;
    else         ent_valid_q <= ent_valid_d;
  end

  // Entry contents carry no reset: they are qualified by the valid bits.
  always_ff @(posedge clk) begin
    if (wr_en) begin
      ent_key_q[wr_idx]  <= wr_key;
      ent_mask_q[wr_idx] <= wr_mask;
      ent_dest_q[wr_idx] <= wr_dest;
    end
  end

  for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
    assign match[e] = ent_valid_q[e] &&
                      ((lk_key & ent_mask_q[e]) == (ent_key_q[e] & ent_mask_q[e]));
  end

  // Isolate the lowest set bit: lowest index has priority.
  assign first  = match & (~match + ENTRIES'(1));
  assign lk_hit = |match;

  always_comb begin
    lk_dest = '0;
    for (int e = 0; e < ENTRIES; e++) begin
      if (first[e]) lk_dest = lk_dest | ent_dest_q[e];
    end
  end

  // R1: a write lands in the addressed valid bit on the next cycle.
  assert_write_lands_R1: assert property (@(posedge clk) disable iff (!rst_ni)
    wr_en |=> (ent_valid_q[$past(wr_idx)] == $past(wr_valid)));

  // R3: at most one entry is selected.
  assert_single_winner_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    $onehot0(first) && (lk_hit == (first != '0)));
endmodule

// File: rtl/mkr_route_select.sv
module mkr_route_select #(
  parameter int unsigned DEST_W = 22
) (
  input  logic                         hit,
  input  logic [DEST_W-1:0]            hit_dest,
  input  logic                         from_link,
  input  logic [mkr_pkg::DIR_W-1:0]    link_dir,
  output logic [DEST_W-1:0]            route_vec
);
  import mkr_pkg::*;

  always_comb begin
    route_vec = '0;
    if (hit) begin
      route_vec = hit_dest;
    end else if (from_link) begin
      route_vec[MESH_LINKS-1:0] = opposite_link(link_dir);
    end
  end
endmodule

// File: rtl/mkr_fanout.sv
module mkr_fanout #(
  parameter int unsigned DEST_W         = 22,
  parameter int unsigned TIMEOUT_CYCLES = 8,
  localparam int unsigned TMR_W         = $clog2(TIMEOUT_CYCLES + 1)
) (
  input  logic                      clk,
  input  logic                      rst_ni,
  input  logic                      acc,
  input  logic [DEST_W-1:0]         acc_vec,
  input  mkr_pkg::mkr_pkt_t         acc_pkt,
  output logic                      busy,
  output logic [DEST_W-1:0]         out_valid,
  input  logic [DEST_W-1:0]         out_ready,
  output mkr_pkg::mkr_pkt_t         out_pkt,
  output logic                      err_valid,
  output logic                      err_unrouted,
  output logic [mkr_pkg::WORD_W-1:0] err_key,
  output logic [DEST_W-1:0]         err_mask
);
  import mkr_pkg::*;

  logic              busy_q, busy_d;
  logic [DEST_W-1:0] pend_q, pend_d;
  logic [TMR_W-1:0]  tmr_q, tmr_d;
  mkr_pkt_t          pkt_q, pkt_d;
  logic              pkt_en;
  logic              errv_q, errv_d;
  logic              errun_q, errun_d;
  logic [WORD_W-1:0] errkey_q, errkey_d;
  logic [DEST_W-1:0] errmask_q, errmask_d;
  logic [DEST_W-1:0] left;
  logic              expire;

  assign left   = pend_q & ~out_ready;
  assign expire = busy_q && (left != '0) && (tmr_q == TMR_W'(TIMEOUT_CYCLES - 1));

  always_comb begin
    busy_d    = busy_q;
    pend_d    = pend_q;
    tmr_d     = tmr_q;
    pkt_en    = 1'b0;
    pkt_d     = acc_pkt;
    errv_d    = 1'b0;
    errun_d   = errun_q;
    errkey_d  = errkey_q;
    errmask_d = errmask_q;
    if (!acc_pkt.ctrl[PAYLOAD_FLAG_BIT]) pkt_d.payload = '0;
    if (busy_q) begin
      tmr_d  = tmr_q + TMR_W'(1);
      pend_d = expire ? '0 : left;
      busy_d = (left != '0) && !expire;
      if (expire) begin
        errv_d    = 1'b1;
        errun_d   = 1'b0;
        errkey_d  = pkt_q.key;
        errmask_d = left;
      end
    end else if (acc) begin
      pkt_en = 1'b1;
      tmr_d  = '0;
      pend_d = acc_vec;
      busy_d = (acc_vec != '0);
      if (acc_vec == '0) begin
        errv_d    = 1'b1;
        errun_d   = 1'b1;
        errkey_d  = acc_pkt.key;
        errmask_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      pend_q <= '0;
      tmr_q  <= '0;
      errv_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      pend_q <= pend_d;
      tmr_q  <= tmr_d;
      errv_q <= errv_d;
    end
  end

  always_ff @(posedge clk) begin
    if (pkt_en) pkt_q <= pkt_d;
    if (errv_d) begin
      errun_q   <= errun_d;
      errkey_q  <= errkey_d;
      errmask_q <= errmask_d;
    end
  end

  assign busy         = busy_q;
  assign out_valid    = pend_q;
  assign out_pkt      = pkt_q;
  assign err_valid    = errv_q;
  assign err_unrouted = errun_q;
  assign err_key      = errkey_q;
  assign err_mask     = errmask_q;

  // R8: while one packet is pending, no output valid bit may rise again.
  assert_valid_only_falls_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    (busy_q && $past(busy_q)) |-> ((out_valid & ~$past(out_valid)) == '0));

  // R4: packet words stay put while the packet is pending.
  assert_words_stable_R4: assert property (@(posedge clk) disable iff (!rst_ni)
    (busy_q && $past(busy_q)) |-> ($stable(out_pkt.key) && $stable(out_pkt.ctrl)));

  // R9: a timeout report names only outputs that were being offered.
  assert_drop_mask_subset_R9: assert property (@(posedge clk) disable iff (!rst_ni)
    (err_valid && !err_unrouted) |-> ((err_mask != '0) && ((err_mask & ~$past(out_valid)) == '0)));

  // R9: the wait counter never passes the limit.
  assert_timer_bound_R9: assert property (@(posedge clk) disable iff (!rst_ni)
    busy_q |-> (tmr_q < TMR_W'(TIMEOUT_CYCLES)));
endmodule

// File: rtl/mcast_key_router.sv
module mcast_key_router #(
  parameter int unsigned NUM_CORES      = 16,
  parameter int unsigned ENTRIES        = 32,
  parameter int unsigned TIMEOUT_CYCLES = 8,
  localparam int unsigned DEST_W        = mkr_pkg::MESH_LINKS + NUM_CORES,
  localparam int unsigned IDX_W         = $clog2(ENTRIES)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_we,
  input  logic [IDX_W-1:0]          cfg_idx,
  input  logic                      cfg_valid,
  input  logic [31:0]               cfg_key,
  input  logic [31:0]               cfg_mask,
  input  logic [DEST_W-1:0]         cfg_dest,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic                      in_from_link,
  input  logic [2:0]                in_link_dir,
  input  logic [31:0]               in_ctrl,
  input  logic [31:0]               in_key,
  input  logic [31:0]               in_payload,
  output logic [DEST_W-1:0]         out_valid,
  input  logic [DEST_W-1:0]         out_ready,
  output logic [31:0]               out_ctrl,
  output logic [31:0]               out_key,
  output logic [31:0]               out_payload,
  output logic                      err_valid,
  output logic                      err_unrouted,
  output logic [31:0]               err_key,
  output logic [DEST_W-1:0]         err_mask
);
  import mkr_pkg::*;

  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic              tbl_hit;
  logic [DEST_W-1:0] tbl_dest;
  logic [DEST_W-1:0] route_vec;
  logic              busy;
  logic              accept;
  mkr_pkt_t          in_pkt;
  mkr_pkt_t          pend_pkt;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign in_pkt = '{ctrl: in_ctrl, key: in_key, payload: in_payload};
  assign in_ready = !busy;
  assign accept   = in_valid && in_ready;

  mkr_key_table #(.ENTRIES(ENTRIES), .DEST_W(DEST_W)) u_table (
    .clk      (clk),
    .rst_ni   (rst_int_n),
    .wr_en    (cfg_we),
    .wr_idx   (cfg_idx),
    .wr_valid (cfg_valid),
    .wr_key   (cfg_key),
    .wr_mask  (cfg_mask),
    .wr_dest  (cfg_dest),
    .lk_key   (in_key),
    .lk_hit   (tbl_hit),
    .lk_dest  (tbl_dest)
  );

  mkr_route_select #(.DEST_W(DEST_W)) u_select (
    .hit       (tbl_hit),
    .hit_dest  (tbl_dest),
    .from_link (in_from_link),
    .link_dir  (in_link_dir),
    .route_vec (route_vec)
  );

  mkr_fanout #(.DEST_W(DEST_W), .TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_fanout (
    .clk          (clk),
    .rst_ni       (rst_int_n),
    .acc          (accept),
    .acc_vec      (route_vec),
    .acc_pkt      (in_pkt),
    .busy         (busy),
    .out_valid    (out_valid),
    .out_ready    (out_ready),
    .out_pkt      (pend_pkt),
    .err_valid    (err_valid),
    .err_unrouted (err_unrouted),
    .err_key      (err_key),
    .err_mask     (err_mask)
  );

  assign out_ctrl    = pend_pkt.ctrl;
  assign out_key     = pend_pkt.key;
  assign out_payload = pend_pkt.payload;

  // R8: no new packet is taken while any output is still offered.
  assert_ready_low_busy_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    (out_valid != '0) |-> !in_ready);

  // R5: a link packet with no match leaves on exactly one link.
  assert_straight_across_R5: assert property (@(posedge clk) disable iff (!rst_int_n)
    (accept && !tbl_hit && in_from_link && (in_link_dir < 3'd6)) |=>
      ($onehot(out_valid) && (out_valid[DEST_W-1:MESH_LINKS] == '0)));

  // R6: an accepted packet with nothing to go to is reported, not sent.
  assert_unrouted_flag_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
    (accept && (route_vec == '0)) |=> (err_valid && err_unrouted && (out_valid == '0)));
endmodule

// File: tb/mcast_key_router_bench.sv
module mcast_key_router_bench;
  localparam int TMO = 5;
  localparam int DW  = 22;

  logic clk = 1'b0;
  logic rst_n;
  logic cfg_we, cfg_valid;
  logic [4:0] cfg_idx;
  logic [31:0] cfg_key, cfg_mask;
  logic [DW-1:0] cfg_dest;
  logic in_valid, in_ready, in_from_link;
  logic [2:0] in_link_dir;
  logic [31:0] in_ctrl, in_key, in_payload;
  logic [DW-1:0] out_valid, out_ready;
  logic [31:0] out_ctrl, out_key, out_payload;
  logic err_valid, err_unrouted;
  logic [31:0] err_key;
  logic [DW-1:0] err_mask;

  int checks = 0;
  int failures = 0;

  bit          m_valid [32];
  logic [31:0] m_key   [32];
  logic [31:0] m_mask  [32];
  logic [DW-1:0] m_dest [32];

  always #5 clk = ~clk;

  mcast_key_router #(.TIMEOUT_CYCLES(TMO)) u_mcast_key_router (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_valid(cfg_valid),
    .cfg_key(cfg_key), .cfg_mask(cfg_mask), .cfg_dest(cfg_dest),
    .in_valid(in_valid), .in_ready(in_ready), .in_from_link(in_from_link),
    .in_link_dir(in_link_dir), .in_ctrl(in_ctrl), .in_key(in_key),
    .in_payload(in_payload), .out_valid(out_valid), .out_ready(out_ready),
    .out_ctrl(out_ctrl), .out_key(out_key), .out_payload(out_payload),
    .err_valid(err_valid), .err_unrouted(err_unrouted),
    .err_key(err_key), .err_mask(err_mask)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] model(input bit fl, input logic [2:0] dir,
                                          input logic [31:0] key);
    for (int e = 0; e < 32; e++) begin
      if (m_valid[e] && ((key & m_mask[e]) == (m_key[e] & m_mask[e]))) return m_dest[e];
    end
    if (fl && dir < 3'd6) return DW'(1) << ((int'(dir) + 3) % 6);
    return '0;
  endfunction

  task automatic wr_entry(input int idx, input bit v, input logic [31:0] k,
                          input logic [31:0] m, input logic [DW-1:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 5'(idx); cfg_valid = v;
    cfg_key = k; cfg_mask = m; cfg_dest = d;
    @(negedge clk);
    cfg_we = 1'b0;
    m_valid[idx] = v; m_key[idx] = k; m_mask[idx] = m; m_dest[idx] = d;
  endtask

  task automatic send(input bit fl, input logic [2:0] dir, input logic [31:0] ctrl,
                      input logic [31:0] key, input logic [31:0] pay,
                      input logic [DW-1:0] rdy, input logic [DW-1:0] late,
                      input int late_at, input string req);
    logic [DW-1:0] exp_dest, stuck, exp_pay;
    int exp_len, seen;
    bit exp_err;
    exp_dest = model(fl, dir, key);
    stuck    = exp_dest & ~rdy & ~((late_at <= TMO) ? late : '0);
    exp_err  = (exp_dest == '0) || (stuck != '0);
    if (exp_dest == '0)            exp_len = 0;
    else if (stuck != '0)          exp_len = TMO;
    else if ((exp_dest & ~rdy) != '0) exp_len = late_at;
    else                           exp_len = 1;
    exp_pay = '0;
    exp_pay = DW'(0);
    @(negedge clk);
    out_ready = rdy;
    in_valid = 1'b1; in_from_link = fl; in_link_dir = dir;
    in_ctrl = ctrl; in_key = key; in_payload = pay;
    chk(in_ready == 1'b1, "R8", "in_ready before accept", 64'(in_ready), 64'd1);
    @(negedge clk);
    in_valid = 1'b0;
    seen = 0;
    for (int k = 1; k < 100; k++) begin
      if (k == 1) begin
        chk(out_valid == exp_dest, req, "vector after accept", 64'(out_valid), 64'(exp_dest));
      end
      if (out_valid == '0) break;
      if (k == 1) begin
        chk(out_key == key, "R4", "out_key", 64'(out_key), 64'(key));
        chk(out_ctrl == ctrl, "R4", "out_ctrl", 64'(out_ctrl), 64'(ctrl));
        chk(out_payload == (ctrl[0] ? pay : 32'd0), "R7", "out_payload",
            64'(out_payload), 64'(ctrl[0] ? pay : 32'd0));
      end
      chk(in_ready == 1'b0, "R8", "in_ready while pending", 64'(in_ready), 64'd0);
      if (k == late_at) out_ready = out_ready | late;
      seen++;
      @(negedge clk);
    end
    chk(seen == exp_len, (exp_len == TMO) ? "R9" : "R8", "pending cycles",
        64'(seen), 64'(exp_len));
    chk(err_valid == exp_err, (exp_dest == '0) ? "R6" : "R9", "err_valid",
        64'(err_valid), 64'(exp_err));
    if (exp_err) begin
      chk(err_unrouted == (exp_dest == '0), (exp_dest == '0) ? "R6" : "R9", "err_unrouted",
          64'(err_unrouted), 64'(exp_dest == '0));
      chk(err_mask == stuck, (exp_dest == '0) ? "R6" : "R9", "err_mask",
          64'(err_mask), 64'(stuck));
      chk(err_key == key, (exp_dest == '0) ? "R6" : "R9", "err_key", 64'(err_key), 64'(key));
    end
    chk(in_ready == 1'b1, "R9", "in_ready after resolve", 64'(in_ready), 64'd1);
    out_ready = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int e = 0; e < 32; e++) begin
      m_valid[e] = 1'b0; m_key[e] = '0; m_mask[e] = '0; m_dest[e] = '0;
    end
    rst_n = 1'b0; cfg_we = 1'b0; cfg_idx = '0; cfg_valid = 1'b0;
    cfg_key = '0; cfg_mask = '0; cfg_dest = '0;
    in_valid = 1'b0; in_from_link = 1'b0; in_link_dir = '0;
    in_ctrl = '0; in_key = '0; in_payload = '0; out_ready = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R10: idle state after reset release
    chk(in_ready == 1'b1, "R10", "in_ready", 64'(in_ready), 64'd1);
    chk(out_valid == '0, "R10", "out_valid", 64'(out_valid), 64'd0);
    chk(err_valid == 1'b0, "R10", "err_valid", 64'(err_valid), 64'd0);

    // R5 / R6: empty table, every arrival direction and a core source
    for (int d = 0; d < 8; d++)
      send(1'b1, 3'(d), 32'h0, 32'h100 + 32'(d), 32'h0, '1, '0, 1, (d < 6) ? "R5" : "R6");
    send(1'b0, 3'd0, 32'h0, 32'hDEAD0001, 32'h0, '1, '0, 1, "R6");

    // R1 / R2 / R4 / R7: single masked entry
    wr_entry(4, 1'b1, 32'hABCD0000, 32'hFFFF0000, 22'h3C0041);
    send(1'b0, 3'd0, 32'h1, 32'hABCD1234, 32'h5A5A5A5A, '1, '0, 1, "R2");
    send(1'b1, 3'd2, 32'h0, 32'hABCDFFFF, 32'h77777777, '1, '0, 1, "R7");
    send(1'b0, 3'd0, 32'h0, 32'hABCE1234, 32'h0, '1, '0, 1, "R2");

    // R3: lower index wins; R1: invalidating re-exposes entry 4
    wr_entry(2, 1'b1, 32'hAB000000, 32'hFF000000, 22'h000102);
    send(1'b0, 3'd0, 32'h0, 32'hABCD0001, 32'h0, '1, '0, 1, "R3");
    wr_entry(2, 1'b0, 32'hAB000000, 32'hFF000000, 22'h000102);
    send(1'b0, 3'd0, 32'h0, 32'hABCD0002, 32'h0, '1, '0, 1, "R1");

    // R6: hit with an empty vector
    wr_entry(7, 1'b1, 32'h55000000, 32'hFF000000, 22'h0);
    send(1'b1, 3'd1, 32'h0, 32'h55001234, 32'h0, '1, '0, 1, "R6");

    // R8 / R9: handshake timing and timeouts on entry 4 (bits 0, 6, 18..21)
    send(1'b0, 3'd0, 32'h0, 32'hABCD0003, 32'h0, ~22'h000040, 22'h000040, 3, "R8");
    send(1'b0, 3'd0, 32'h0, 32'hABCD0004, 32'h0, ~22'h000040, 22'h000040, TMO, "R9");
    send(1'b0, 3'd0, 32'h0, 32'hABCD0005, 32'h0, ~22'h000040, 22'h000040, TMO + 1, "R9");
    send(1'b0, 3'd0, 32'h1, 32'hABCD0006, 32'h12345678, 22'h000001, '0, 1, "R9");

    // Sweep over an overlapping table
    for (int e = 8; e < 24; e++)
      wr_entry(e, 1'b1, 32'(e % 8) << 28, (e < 16) ? 32'hF0000000 : 32'h30000000,
               DW'((e * 32'h2F5B1 + 1) & 32'h3FFFFF));
    for (int i = 0; i < 64; i++) begin
      logic [21:0] r;
      r = (i % 5 == 0) ? ~(DW'(1) << (i % 22)) : '1;
      send((i % 3) != 0, 3'(i % 8), 32'(i & 1), (32'(i) << 26) | 32'(i), 32'(i * 7),
           r, DW'(1) << (i % 22), (i % 10 == 0) ? 2 : TMO + 2, "R4");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule